// File: doc/BRIEF.md
# Rectangular Word-Copy Sequencer

This block is the control engine of a two-dimensional memory copier. Software loads a start source address, a start destination address, four signed byte increments (per word and per line, for each side) and the size of the rectangle in words per line and lines. It then writes the start bit. The engine walks the rectangle one 16-bit word at a time. For each word it issues a read of the source and then a write of the destination. It waits for an acknowledge on each access, then steps both addresses.

The engine does not own the memory bus. It raises a bus request and waits for a grant before it accesses memory. In exclusive mode it keeps the bus until the whole rectangle is done. In shared mode it hands the bus back after a fixed slice of clocks, waits one slice length, and then asks for the bus again. Writing the start bit during such a pause makes it ask for the bus again at once. The addresses and counts are working registers that the run consumes, so software must reload them before each copy.

Top module: `blk_seq`

## Requirements
- R1: After a start, the engine performs exactly X-count × Y-count word transfers. Each transfer is a read (`mem_we`=0) at the current source address followed by a write (`mem_we`=1) at the current destination address.
- R2: After every word except the last of a line, each address advances by its signed word increment. After the last word of a line, each address advances by its signed line increment instead, and the word count reloads. Negative increments walk memory downward, and all arithmetic wraps at the address width.
- R3: Bit 0 of both loaded addresses is cleared, and bit 0 of the source word increment is ignored, so every `mem_addr` is even.
- R4: A `go` pulse while idle, with both counts nonzero, sets `busy` on the next clock. `busy` stays 1 through the acknowledge of the final write and is 0 on the clock after it.
- R5: In exclusive mode (`cfg_hog`=1, sampled at `go`), `bus_req` stays high from the start until the run ends, and no pause occurs.
- R6: In shared mode (`cfg_hog`=0), after a slice of SLICE clocks of bus ownership the engine drops `bus_req` at the first word boundary. It keeps it low for exactly SLICE clocks while `busy` stays 1, and then requests again. No pause follows the final word.
- R7: A `go` pulse during a shared-mode pause ends the pause at once: `bus_req` rises on the next clock.
- R8: The run consumes the working counts. A second `go` with no new `ld` starts nothing. A `go` with a zero X or Y count also starts nothing: `busy` and `bus_req` stay 0 and no access occurs.
- R9: An `ld` pulse while `busy` is 1 has no effect on the running copy's addresses or counts.
- R10: `bus_req` is held until `bus_grant`. `mem_req` is only raised while the bus is granted, and each access holds its address and direction until `mem_ack`.
- R11: After reset, `busy`, `bus_req` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld | input | 1 | Load working registers from cfg_* (ignored while busy) |
| cfg_src | input | AW | Start source byte address |
| cfg_dst | input | AW | Start destination byte address |
| cfg_src_xinc | input | IW | Signed source step per word |
| cfg_src_yinc | input | IW | Signed source step at line end |
| cfg_dst_xinc | input | IW | Signed destination step per word |
| cfg_dst_yinc | input | IW | Signed destination step at line end |
| cfg_xcnt | input | CW | Words per line |
| cfg_ycnt | input | CW | Number of lines |
| cfg_hog | input | 1 | 1 = exclusive bus mode, 0 = shared slices |
| go | input | 1 | Start bit write; restarts from a pause |
| busy | output | 1 | Copy in progress |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | 1 = write destination, 0 = read source |
| mem_addr | output | AW | Byte address of the access |
| mem_ack | input | 1 | Access complete |

## Verification
The bench builds the engine with a 20-bit address, 16-bit increments, 8-bit counts and SLICE set to 8 instead of 64. With the bench's memory answering every second cycle, a word takes four clocks. A shared-mode copy of twelve words therefore yields five pauses, and each pause length can be counted exactly within a short run. The early restart is reached a few clocks into a pause. Address wrap and downward walks are reached with small negative increments. The odd start address and the odd word step show whether bit 0 is masked.

// File: rtl/blk_seq.sv
module blk_seq #(
  parameter int AW    = 24,
  parameter int IW    = 16,
  parameter int CW    = 16,
  parameter int SLICE = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [IW-1:0] cfg_src_xinc,
  input  logic [IW-1:0] cfg_src_yinc,
  input  logic [IW-1:0] cfg_dst_xinc,
  input  logic [IW-1:0] cfg_dst_yinc,
  input  logic [CW-1:0] cfg_xcnt,
  input  logic [CW-1:0] cfg_ycnt,
  input  logic          cfg_hog,
  input  logic          go,
  output logic          busy,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack
);
  localparam int SW = $clog2(SLICE + 1);
  localparam logic [SW-1:0] SLICE_END = SW'(SLICE - 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_PAUSE} st_t;

  st_t            st;
  logic [AW-2:0]  src_w, dst_w;
  logic [IW-1:0]  sxi, syi, dxi, dyi;
  logic [CW-1:0]  xcnt, xshadow, ycnt;
  logic           hog_q;
  logic [SW-1:0]  slice_cnt, pause_cnt;

  function automatic logic [AW-2:0] step(input logic [AW-2:0] w, input logic [IW-1:0] inc);
    logic [AW-1:0] b;
    b = {w, 1'b0} + AW'($signed(inc));
    return b[AW-1:1];
  endfunction

  logic word_done, end_of_line, last_word, can_start;
  assign word_done   = (st == S_WR) && mem_ack;
  assign end_of_line = (xcnt == CW'(1));
  assign last_word   = end_of_line && (ycnt == CW'(1));
  assign can_start   = (xcnt != '0) && (ycnt != '0);

  assign busy     = (st != S_IDLE);
  assign bus_req  = (st == S_REQ) || (st == S_RD) || (st == S_WR);
  assign mem_req  = (st == S_RD) || (st == S_WR);
  assign mem_we   = (st == S_WR);
  assign mem_addr = (st == S_WR) ? {dst_w, 1'b0} : {src_w, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      src_w     <= '0;
      dst_w     <= '0;
      sxi       <= '0;
      syi       <= '0;
      dxi       <= '0;
      dyi       <= '0;
      xcnt      <= '0;
      xshadow   <= '0;
      ycnt      <= '0;
      hog_q     <= 1'b0;
      slice_cnt <= '0;
      pause_cnt <= '0;
    end else begin
      if (st == S_RD || st == S_WR) begin
        if (slice_cnt != SW'(SLICE)) slice_cnt <= slice_cnt + 1'b1;
      end
      unique case (st)
        S_IDLE: begin
          if (ld) begin
            src_w   <= cfg_src[AW-1:1];
            dst_w   <= cfg_dst[AW-1:1];
            sxi     <= {cfg_src_xinc[IW-1:1], 1'b0};
            syi     <= cfg_src_yinc;
            dxi     <= cfg_dst_xinc;
            dyi     <= cfg_dst_yinc;
            xcnt    <= cfg_xcnt;
            xshadow <= cfg_xcnt;
            ycnt    <= cfg_ycnt;
          end else if (go && can_start) begin
            hog_q <= cfg_hog;
            st    <= S_REQ;
          end
        end
        S_REQ: begin
          if (bus_grant) begin
            slice_cnt <= '0;
            st        <= S_RD;
          end
        end
        S_RD: begin
          if (mem_ack) st <= S_WR;
        end
        S_WR: begin
          if (mem_ack) begin
            if (end_of_line) begin
              src_w <= step(src_w, syi);
              dst_w <= step(dst_w, dyi);
              xcnt  <= xshadow;
              ycnt  <= ycnt - 1'b1;
            end else begin
              src_w <= step(src_w, sxi);
              dst_w <= step(dst_w, dxi);
              xcnt  <= xcnt - 1'b1;
            end
            if (last_word) begin
              st <= S_IDLE;
            end else if (!hog_q && slice_cnt >= SLICE_END) begin
              pause_cnt <= '0;
              st        <= S_PAUSE;
            end else begin
              st <= S_RD;
            end
          end
        end
        S_PAUSE: begin
          pause_cnt <= pause_cnt + 1'b1;
          if (go || pause_cnt == SLICE_END) st <= S_REQ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10
  grant_before_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_grant && bus_req);

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3
  even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[0] == 1'b0);

  // R5
  hog_holds_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hog_q && bus_req |=> bus_req || !busy);

  // R4
  busy_during_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R8
  counts_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> xcnt != '0 && ycnt != '0);

  // R6
  pause_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAUSE) |-> !bus_req && !mem_req && busy);
endmodule

// File: tb/blk_seq_tb.sv
`timescale 1ns/1ps
module blk_seq_tb;
  localparam int AW = 20, IW = 16, CW = 8, SLICE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld = 1'b0, go = 1'b0, hog = 1'b0;
  logic [AW-1:0] csrc = '0, cdst = '0;
  logic [IW-1:0] csxi = '0, csyi = '0, cdxi = '0, cdyi = '0;
  logic [CW-1:0] cxc = '0, cyc = '0;
  logic busy, bus_req, mem_req, mem_we;
  logic bus_grant = 1'b0, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  blk_seq #(.AW(AW), .IW(IW), .CW(CW), .SLICE(SLICE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld(ld),
    .cfg_src(csrc), .cfg_dst(cdst),
    .cfg_src_xinc(csxi), .cfg_src_yinc(csyi),
    .cfg_dst_xinc(cdxi), .cfg_dst_yinc(cdyi),
    .cfg_xcnt(cxc), .cfg_ycnt(cyc), .cfg_hog(hog),
    .go(go), .busy(busy), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
  );

  always @(posedge clk) begin
    bus_grant <= rst_n && bus_req;
    mem_ack   <= rst_n && mem_req && !mem_ack;
  end

  logic [AW-1:0] la [0:511];
  logic          lw [0:511];
  int ln = 0;
  int pl [0:127];
  int np = 0, plen = 0;

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      la[ln] <= mem_addr;
      lw[ln] <= mem_we;
      ln     <= ln + 1;
    end
    if (rst_n && busy && !bus_req) plen <= plen + 1;
    else if (plen != 0) begin
      pl[np] <= plen;
      np     <= np + 1;
      plen   <= 0;
    end
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input int sx, input int sy, input int dx, input int dy,
                      input int xc, input int yc);
    @(negedge clk);
    csrc = s; cdst = d;
    csxi = IW'(sx); csyi = IW'(sy); cdxi = IW'(dx); cdyi = IW'(dy);
    cxc = CW'(xc); cyc = CW'(yc);
    ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic start(input logic h);
    @(negedge clk);
    hog = h; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
  endtask

  task automatic check_seq(input string req, input int n0,
                           input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                           input int sx, input int sy, input int dx, input int dy,
                           input int xc, input int yc);
    logic [AW-1:0] s, d, sxm;
    int k;
    s = s0 & ~AW'(1); d = d0 & ~AW'(1);
    sxm = AW'(sx) & ~AW'(1);
    k = n0;
    check(ln - n0 == 2 * xc * yc, req, "access count", ln - n0, 2 * xc * yc);
    for (int y = 0; y < yc; y++) begin
      for (int x = 0; x < xc; x++) begin
        if (la[k] !== s || lw[k] !== 1'b0) check(0, req, "read addr", la[k], s);
        if (la[k+1] !== d || lw[k+1] !== 1'b1) check(0, req, "write addr", la[k+1], d);
        k += 2;
        if (x == xc - 1) begin
          s = (s + AW'(sy)) & ~AW'(1);
          d = (d + AW'(dy)) & ~AW'(1);
        end else begin
          s = s + sxm;
          d = (d + AW'(dx)) & ~AW'(1);
        end
      end
    end
    check(1, req, "sequence", 0, 0);
  endtask

  task automatic t_reset();
    check(busy == 0, "R11", "busy", busy, 0);
    check(bus_req == 0, "R11", "bus_req", bus_req, 0);
    check(mem_req == 0, "R11", "mem_req", mem_req, 0);
  endtask

  task automatic t_hog_forward();
    int n0 = ln, p0 = np, c = 0;
    bit dropped = 0;
    load(20'h01000, 20'h08000, 2, 10, 2, 40, 4, 3);
    start(1'b1);
    check(busy == 1, "R4", "busy after go", busy, 1);
    while (busy && c < 5000) begin
      @(negedge clk);
      if (busy && !bus_req && c > 2) dropped = 1;
      c++;
    end
    check(!dropped, "R5", "bus_req dropped in exclusive mode", dropped, 0);
    check(np == p0, "R5", "pause count", np - p0, 0);
    check(busy == 0, "R4", "busy after last write", busy, 0);
    check_seq("R1", n0, 20'h01000, 20'h08000, 2, 10, 2, 40, 4, 3);
  endtask

  task automatic t_shared_backward();
    int n0 = ln, p0 = np;
    bit lenok = 1;
    load(20'h02000, 20'h00010, -2, -20, -4, 100, 6, 2);
    start(1'b0);
    wait_idle();
    check_seq("R2", n0, 20'h02000, 20'h00010, -2, -20, -4, 100, 6, 2);
    check(np - p0 == 5, "R6", "pause count", np - p0, 5);
    for (int i = p0; i < np; i++) if (pl[i] != SLICE) begin
      lenok = 0;
      check(0, "R6", "pause length", pl[i], SLICE);
    end
    check(lenok, "R6", "all pause lengths", lenok, 1);
  endtask

  task automatic t_odd_and_reload();
    int n0 = ln, n1;
    load(20'h03001, 20'h0A001, 3, 6, 2, 8, 3, 2);
    start(1'b1);
    wait_idle();
    check_seq("R3", n0, 20'h03001, 20'h0A001, 3, 6, 2, 8, 3, 2);
    check(la[n0] == 20'h03000, "R3", "first read even", la[n0], 20'h03000);
    n1 = ln;
    start(1'b1);
    repeat (6) @(negedge clk);
    check(busy == 0, "R8", "busy on go without reload", busy, 0);
    check(ln == n1, "R8", "accesses without reload", ln - n1, 0);
  endtask

  task automatic t_zero_count();
    int n1;
    load(20'h04000, 20'h05000, 2, 2, 2, 2, 0, 4);
    n1 = ln;
    start(1'b0);
    repeat (6) @(negedge clk);
    check(busy == 0 && bus_req == 0, "R8", "busy with zero x count", busy, 0);
    check(ln == n1, "R8", "accesses with zero x count", ln - n1, 0);
  endtask

  task automatic t_restart();
    int n0 = ln, p0 = np, c = 0;
    load(20'h06000, 20'h07000, 2, 2, 2, 2, 8, 1);
    start(1'b0);
    while (!(busy && !bus_req) && c < 5000) begin
      @(negedge clk);
      c++;
    end
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    check(bus_req == 1, "R7", "bus_req after restart", bus_req, 1);
    wait_idle();
    check(np > p0 && pl[p0] < SLICE, "R7", "shortened pause", pl[p0], 2);
    check_seq("R7", n0, 20'h06000, 20'h07000, 2, 2, 2, 2, 8, 1);
  endtask

  task automatic t_load_while_busy();
    int n0 = ln, c = 0;
    load(20'h0B000, 20'h0C000, 2, 4, 2, 6, 6, 2);
    start(1'b1);
    while (ln < n0 + 4 && c < 5000) begin
      @(negedge clk);
      c++;
    end
    load(20'h0E000, 20'h0F000, 8, 8, 8, 8, 1, 1);
    wait_idle();
    check_seq("R9", n0, 20'h0B000, 20'h0C000, 2, 4, 2, 6, 6, 2);
  endtask

  task automatic t_grant_delay();
    int n0 = ln;
    load(20'h00100, 20'h00200, 2, 2, 2, 2, 2, 1);
    start(1'b1);
    check(bus_req == 1 && mem_req == 0, "R10", "request before grant", mem_req, 0);
    wait_idle();
    check(bus_req == 0, "R10", "bus_req after run", bus_req, 0);
    check_seq("R10", n0, 20'h00100, 20'h00200, 2, 2, 2, 2, 2, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hog_forward();
    t_shared_backward();
    t_odd_and_reload();
    t_zero_count();
    t_restart();
    t_load_while_busy();
    t_grant_delay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule